// File: doc/BRIEF.md
# UART Receive Line Monitor

This block watches an asynchronous serial receive line. A bit-rate enable from elsewhere marks the one clock per bit time in which the line is sampled. Each sample can be inverted first. The block then takes characters apart: a start bit, 8, 9 or 10 payload bits (the last one may be a parity bit), and one or two stop bits. Payload bits can arrive least- or most-significant first. The block also tracks how long the line has been low, so that it can report break characters, and how long it has been high after a character, so that it can report an idle line.

The block has no storage past the last received word. It delivers the word with a one-cycle strobe. Break, idle and framing error are one-cycle pulses. A receiver-active level shows when the line is carrying traffic. A standby input and a wake-mode select decide whether an idle line is reported while the receiver sleeps. For address-based wake-up, an external comparator supplies an address-mismatch level. The configuration inputs are expected to stay stable while a character is in flight.

Top module: `uart_rx_monitor`

## Requirements
- R1: When `inv_en` is 1, every sample of `rx_in` is complemented before any other use, including idle level, start, data, stop and break. The same logical character sent with the opposite wire polarity yields the same result.
- R2: Payload size B is 10 if `len10`=1, otherwise 9 if `len9`=1, otherwise 8. With `parity_en`=1 the last payload bit always lands in `rx_data[B-1]`, and the D = B-`parity_en` data bits fill bits D-1..0. With `msb_first`=0 the first received bit goes to bit 0. With `msb_first`=1 it goes to bit D-1. Unused upper bits of `rx_data` read 0.
- R3: The frame length F is 1+B+S, where S is 2 if `stop2`=1 and 1 otherwise. With `ext_break`=0, `break_det` pulses on the sample that completes a run of exactly F consecutive low samples. Such a character produces neither `rx_valid` nor `frame_err`.
- R4: With `ext_break`=1, the break run length for F = 10, 11, 12 and 13 is 11, 12, 14 and 15 respectively.
- R5: While `ext_break`=1, `rx_valid` never pulses.
- R6: One cycle after the tick that samples the last stop bit, `rx_valid` pulses with the assembled word on `rx_data`, unless R3 or R5 applies. `rx_data` holds its value until the next such pulse.
- R7: `frame_err` pulses in that same cycle when any stop-bit sample was low and the low run has not reached the break length. In this case data is still delivered under R6.
- R8: `rx_active` rises on the tick that accepts a start bit. It falls only on an idle detection.
- R9: An idle detection happens once after each character, on the F-th consecutive high sample counted from the first high tick after the frame ends.
- R10: On an idle detection, `idle_flag` pulses unless the receiver is asleep and `idle_report`=0. With `wake_addr`=0, the receiver is asleep when `standby`=1.
- R11: With `wake_addr`=1, the receiver is asleep only when `standby`=1 and `addr_miss`=1. So while sleeping, a non-matching address reports idle only if `idle_report`=1.
- R12: Outputs change only one cycle after a `bit_tick`. After reset all outputs are 0, and a start bit is accepted only after at least one high sample has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time; the line is sampled on it |
| rx_in | input | 1 | Raw serial receive line |
| inv_en | input | 1 | Complement the line before use |
| msb_first | input | 1 | Payload bit order select |
| len9 | input | 1 | 9-bit payload |
| len10 | input | 1 | 10-bit payload (overrides len9) |
| parity_en | input | 1 | Last payload bit is parity |
| stop2 | input | 1 | Two stop bits |
| ext_break | input | 1 | Longer break length, data output suppressed |
| standby | input | 1 | Receiver sleeping |
| wake_addr | input | 1 | Wake mode is address match instead of idle line |
| addr_miss | input | 1 | Last address did not match (from external comparator) |
| idle_report | input | 1 | Report idle even while asleep |
| rx_data | output | 10 | Last received word |
| rx_valid | output | 1 | Word strobe |
| break_det | output | 1 | Break detected pulse |
| idle_flag | output | 1 | Idle detected pulse |
| rx_active | output | 1 | Receiver active level |
| frame_err | output | 1 | Framing error pulse |

## Verification
The same wire bit sequence is sent under LSB-first, MSB-first, MSB-first with parity and a 10-bit MSB-first format. Each mapping gives a distinct word, so a wrong index, a misplaced parity bit or a wrong payload length all show up. Low runs are stopped one sample short of each threshold and then extended by one sample, in normal and extended mode, for the shortest and the longest frame. These runs separate break from framing error and catch an off-by-one threshold. Idle reporting is tried awake, asleep under both wake modes, and with a matching and a non-matching address. The exact cycle of every pulse is compared against a behavioural model.

// File: rtl/uart_rx_monitor.sv
module uart_rx_monitor #(
  parameter int RUN_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       rx_in,
  input  logic       inv_en,
  input  logic       msb_first,
  input  logic       len9,
  input  logic       len10,
  input  logic       parity_en,
  input  logic       stop2,
  input  logic       ext_break,
  input  logic       standby,
  input  logic       wake_addr,
  input  logic       addr_miss,
  input  logic       idle_report,
  output logic [9:0] rx_data,
  output logic       rx_valid,
  output logic       break_det,
  output logic       idle_flag,
  output logic       rx_active,
  output logic       frame_err
);

  localparam logic [RUN_W-1:0] ONE = RUN_W'(1);

  typedef enum logic [1:0] {WAIT_HI, LISTEN, IN_FRAME} rx_state_t;

  rx_state_t        state;
  logic [3:0]       pos;
  logic [9:0]       shift;
  logic             stop_bad;
  logic             armed;
  logic [RUN_W-1:0] low_run;
  logic [RUN_W-1:0] high_cnt;

  logic             line;
  logic [3:0]       nbits, ndata, nstop, idx;
  logic [RUN_W-1:0] nframe, thr, low_run_nx;
  logic             last_pos, brk_hit, brk_now, asleep;

  assign line   = rx_in ^ inv_en;
  assign nbits  = len10 ? 4'd10 : (len9 ? 4'd9 : 4'd8);
  assign ndata  = nbits - {3'b000, parity_en};
  assign nstop  = stop2 ? 4'd2 : 4'd1;
  assign nframe = RUN_W'(nbits) + RUN_W'(nstop) + ONE;

  always_comb begin
    thr = nframe;
    if (ext_break) begin
      case (nframe)
        RUN_W'(10): thr = RUN_W'(11);
        RUN_W'(11): thr = RUN_W'(12);
        RUN_W'(12): thr = RUN_W'(14);
        default:    thr = RUN_W'(15);
      endcase
    end
  end

  assign idx = (parity_en && pos == nbits - 4'd1) ? nbits - 4'd1 :
               msb_first ? ndata - 4'd1 - pos : pos;

  assign low_run_nx = (&low_run) ? low_run : low_run + ONE;
  assign brk_hit    = ~line && (low_run + ONE == thr);
  assign brk_now    = ~line && (low_run_nx >= thr);
  assign last_pos   = pos == nbits + nstop - 4'd1;
  assign asleep     = standby && (!wake_addr || addr_miss);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= WAIT_HI;
      pos       <= '0;
      shift     <= '0;
      stop_bad  <= 1'b0;
      armed     <= 1'b0;
      low_run   <= '0;
      high_cnt  <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      break_det <= 1'b0;
      idle_flag <= 1'b0;
      rx_active <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      break_det <= 1'b0;
      idle_flag <= 1'b0;
      frame_err <= 1'b0;
      if (bit_tick) begin
        low_run   <= line ? '0 : low_run_nx;
        break_det <= brk_hit;
        case (state)
          WAIT_HI: if (line) state <= LISTEN;
          LISTEN: begin
            if (!line) begin
              state     <= IN_FRAME;
              pos       <= '0;
              shift     <= '0;
              stop_bad  <= 1'b0;
              rx_active <= 1'b1;
            end else if (armed) begin
              if (high_cnt + ONE == nframe) begin
                armed     <= 1'b0;
                high_cnt  <= '0;
                rx_active <= 1'b0;
                idle_flag <= !asleep || idle_report;
              end else begin
                high_cnt <= high_cnt + ONE;
              end
            end
          end
          IN_FRAME: begin
            if (pos < nbits) shift[idx] <= line;
            else if (!line) stop_bad <= 1'b1;
            pos <= pos + 4'd1;
            if (last_pos) begin
              if (!ext_break && !brk_now) begin
                rx_valid <= 1'b1;
                rx_data  <= shift;
              end
              frame_err <= (stop_bad || !line) && !brk_now;
              armed     <= 1'b1;
              high_cnt  <= '0;
              state     <= line ? LISTEN : WAIT_HI;
            end
          end
          default: state <= WAIT_HI;
        endcase
      end
    end
  end

endmodule

module uart_rx_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic rx_in,
  input logic inv_en,
  input logic ext_break,
  input logic standby,
  input logic wake_addr,
  input logic idle_report,
  input logic rx_valid,
  input logic break_det,
  input logic idle_flag,
  input logic rx_active,
  input logic frame_err
);

  // R12
  quiet_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> !(rx_valid || break_det || idle_flag || frame_err));

  // R5
  ext_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && ext_break |=> !rx_valid);

  // R3
  break_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    break_det |-> !rx_valid && !frame_err);

  // R8
  act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(bit_tick) && !($past(rx_in) ^ $past(inv_en)));

  // R9
  idle_clears_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_flag |-> !rx_active);

  // R6
  valid_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_active);

  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && standby && !wake_addr && !idle_report |=> !idle_flag);

endmodule

bind uart_rx_monitor uart_rx_monitor_chk u_chk (.*);

// File: tb/uart_rx_monitor_tb.sv
`timescale 1ns/1ps
module uart_rx_monitor_tb;
  logic clk = 0, rst_n = 0, bit_tick = 0, rx_in = 1;
  logic inv_en = 0, msb_first = 0, len9 = 0, len10 = 0, parity_en = 0, stop2 = 0;
  logic ext_break = 0, standby = 0, wake_addr = 0, addr_miss = 0, idle_report = 0;
  logic [9:0] rx_data;
  logic rx_valid, break_det, idle_flag, rx_active, frame_err;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_monitor u_dut (.*);

  // reference model state
  int m_st = 0, m_low = 0, m_hi = 0;
  bit m_armed = 0;
  bit q[$];
  logic [9:0] e_data = 0;
  bit e_valid = 0, e_brk = 0, e_idle = 0, e_act = 0, e_fe = 0;
  bit saw_valid = 0, saw_brk = 0, saw_idle = 0, saw_fe = 0;
  logic [9:0] last_data = 0;

  function automatic int f_b(); return len10 ? 10 : (len9 ? 9 : 8); endfunction
  function automatic int f_s(); return stop2 ? 2 : 1; endfunction
  function automatic int f_thr();
    int f = 1 + f_b() + f_s();
    if (!ext_break) return f;
    case (f) 10: return 11; 11: return 12; 12: return 14; default: return 15; endcase
  endfunction

  task automatic fail(string tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_low = 0; m_hi = 0; m_armed = 0; q.delete();
      e_data = 0; e_valid = 0; e_brk = 0; e_idle = 0; e_act = 0; e_fe = 0;
    end else begin
      e_valid = 0; e_brk = 0; e_idle = 0; e_fe = 0;
      if (bit_tick) begin
        bit l;
        l = rx_in ^ inv_en;
        if (!l) begin m_low++; if (m_low == f_thr()) e_brk = 1; end
        else m_low = 0;
        if (m_st == 0) begin
          if (l) m_st = 1;
        end else if (m_st == 1) begin
          if (!l) begin m_st = 2; q.delete(); e_act = 1; end
          else if (m_armed) begin
            m_hi++;
            if (m_hi == 1 + f_b() + f_s()) begin
              m_armed = 0; m_hi = 0; e_act = 0;
              e_idle = !(standby && (!wake_addr || addr_miss)) || idle_report;
            end
          end
        end else begin
          q.push_back(l);
          if (q.size() == f_b() + f_s()) begin
            logic [9:0] d;
            bit ok, brk;
            int nd;
            d = 0; ok = 1;
            nd = f_b() - int'(parity_en);
            for (int j = 0; j < f_b(); j++) begin
              if (parity_en && j == f_b() - 1) d[j] = q[j];
              else if (msb_first) d[nd-1-j] = q[j];
              else d[j] = q[j];
            end
            for (int j = f_b(); j < f_b() + f_s(); j++) if (!q[j]) ok = 0;
            brk = !l && m_low >= f_thr();
            if (!ext_break && !brk) begin e_valid = 1; e_data = d; end
            e_fe = !ok && !brk;
            m_armed = 1; m_hi = 0;
            m_st = l ? 1 : 0;
          end
        end
      end
    end
    #1;
    checks++;
    if (rx_data !== e_data)     fail("R2", "rx_data", rx_data, e_data);
    if (rx_valid !== e_valid)   fail("R6", "rx_valid", rx_valid, e_valid);
    if (break_det !== e_brk)    fail("R3", "break_det", break_det, e_brk);
    if (frame_err !== e_fe)     fail("R7", "frame_err", frame_err, e_fe);
    if (idle_flag !== e_idle)   fail("R10", "idle_flag", idle_flag, e_idle);
    if (rx_active !== e_act)    fail("R8", "rx_active", rx_active, e_act);
    if (rx_valid) begin saw_valid = 1; last_data = rx_data; end
    if (break_det) saw_brk = 1;
    if (idle_flag) saw_idle = 1;
    if (frame_err) saw_fe = 1;
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) fail(tag, what, act, exp);
  endtask

  task automatic clr();
    saw_valid = 0; saw_brk = 0; saw_idle = 0; saw_fe = 0;
  endtask

  task automatic bitx(input bit v);
    @(negedge clk); rx_in = v ^ inv_en; bit_tick = 1;
    @(negedge clk); bit_tick = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic highs(input int n); for (int i = 0; i < n; i++) bitx(1); endtask
  task automatic lows(input int n);  for (int i = 0; i < n; i++) bitx(0); endtask

  task automatic send(input logic [9:0] w, input int n, input bit stp);
    bitx(0);
    for (int i = 0; i < n; i++) bitx(w[i]);
    for (int i = 0; i < f_s(); i++) bitx(stp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "reset outputs", {rx_valid, break_det, idle_flag, rx_active, frame_err, rx_data}, 0);
    rst_n = 1;
    lows(5);
    chk("R12", "no start before high", rx_active, 0);
    highs(2);

    clr(); send(10'h035, 8, 1);
    chk("R6", "valid lsb", saw_valid, 1);
    chk("R2", "lsb word", last_data, 10'h035);
    chk("R8", "active after frame", rx_active, 1);
    highs(9);
    chk("R9", "no idle one short", saw_idle, 0);
    highs(1);
    chk("R9", "idle after F highs", saw_idle, 1);
    chk("R8", "active cleared", rx_active, 0);

    msb_first = 1;
    clr(); send(10'h035, 8, 1); highs(10);
    chk("R2", "msb word", last_data, 10'h0AC);
    parity_en = 1;
    clr(); send(10'h035, 8, 1); highs(10);
    chk("R2", "msb parity word", last_data, 10'h056);
    parity_en = 0; len10 = 1;
    clr(); send(10'b10_0000_0011, 10, 1); highs(12);
    chk("R2", "10-bit msb word", last_data, 10'h301);
    len10 = 0; msb_first = 0;

    inv_en = 1; highs(2);
    clr(); send(10'h035, 8, 1); highs(10);
    chk("R1", "inverted word", last_data, 10'h035);
    chk("R1", "inverted idle", saw_idle, 1);
    clr(); lows(9);
    chk("R1", "inverted no early break", saw_brk, 0);
    lows(1);
    chk("R1", "inverted break", saw_brk, 1);
    highs(2); inv_en = 0; highs(2);

    clr(); send(10'h081, 8, 0); highs(12);
    chk("R7", "stop low fe", saw_fe, 1);
    chk("R7", "stop low data", last_data, 10'h081);

    clr(); lows(9);
    chk("R3", "no break at 9", saw_brk, 0);
    lows(1);
    chk("R3", "break at 10", saw_brk, 1);
    chk("R3", "break no valid", saw_valid, 0);
    chk("R3", "break no fe", saw_fe, 0);
    highs(12);

    ext_break = 1;
    clr(); lows(10);
    chk("R4", "ext fe at frame end", saw_fe, 1);
    chk("R4", "ext no break at 10", saw_brk, 0);
    lows(1);
    chk("R4", "ext break at 11", saw_brk, 1);
    highs(12);
    clr(); send(10'h035, 8, 1); highs(10);
    chk("R5", "ext suppresses valid", saw_valid, 0);
    chk("R5", "ext data held", rx_data, 10'h081);

    len10 = 1; stop2 = 1; ext_break = 0;
    clr(); lows(12);
    chk("R4", "long frame no break at 12", saw_brk, 0);
    lows(1);
    chk("R4", "long frame break at 13", saw_brk, 1);
    highs(14);
    ext_break = 1;
    clr(); lows(14);
    chk("R4", "long ext no break at 14", saw_brk, 0);
    lows(1);
    chk("R4", "long ext break at 15", saw_brk, 1);
    highs(14);
    len10 = 0; stop2 = 0; ext_break = 0;

    standby = 1;
    clr(); send(10'h011, 8, 1); highs(10);
    chk("R10", "asleep no idle flag", saw_idle, 0);
    chk("R10", "asleep active cleared", rx_active, 0);
    idle_report = 1;
    clr(); send(10'h011, 8, 1); highs(10);
    chk("R10", "asleep with report", saw_idle, 1);
    idle_report = 0; wake_addr = 1;
    clr(); send(10'h022, 8, 1); highs(10);
    chk("R11", "address matched idle", saw_idle, 1);
    addr_miss = 1;
    clr(); send(10'h022, 8, 1); highs(10);
    chk("R11", "address mismatch no idle", saw_idle, 0);
    idle_report = 1;
    clr(); send(10'h022, 8, 1); highs(10);
    chk("R11", "address mismatch with report", saw_idle, 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule